// File: doc/BRIEF.md
# Interleaved Burst Protocol Monitor

A passive observer for a transmit user interface on which packets travel as bursts over an eight-word bus, with bursts from different channels free to interleave. Every clock it samples the start-of-packet, start-of-burst and end-of-burst strobes, the channel field, the valid-word count and the four-bit end-of-packet code. It never touches payload data.

The monitor keeps the channel of the burst in progress and, for every channel, an open-packet flag and a running byte total. When a packet's final cycle arrives it reports the channel and the packet's total byte count for one cycle. Rule breaks in the strobe sequence are flagged both as a per-cycle pulse vector and as a sticky vector that holds until reset. A synchronous active-high reset clears all state.

Top module: `ilv_burst_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pkt_done`, `pkt_chan`, `pkt_bytes`, `err_pulse` and `err_sticky` are zero, no burst is in progress and every channel is closed.
- R2: A cycle with `tx_nvalid` equal to 0 is idle: it changes no state and raises no output, whatever the other inputs carry.
- R3: An end-of-packet cycle has `tx_eop_code[3]` set. Such a cycle adds 8*(count-1) bytes plus the low three code bits, or 8 when those bits are 0. Any other active cycle adds 8*count bytes.
- R4: One clock after the final cycle of a packet, `pkt_done` is high for one cycle, with the packet's channel on `pkt_chan` and its total bytes on `pkt_bytes`. That channel is then closed.
- R5: A cycle with `tx_sob` set opens a burst on `tx_chan`, and a cycle with `tx_eob` set closes it. Cycles in between belong to that channel. Each channel keeps its own open flag and total across interleaved bursts. A burst without start-of-packet adds to its channel's open packet.
- R6: `err_pulse[0]`: start-of-packet with start-of-burst on a channel that is already open. The old total is dropped and a new packet starts.
- R7: `err_pulse[1]`: a start-of-burst without start-of-packet on a closed channel. The data of that burst is not counted.
- R8: `err_pulse[2]`: an active cycle with no burst in progress and no start-of-burst. Its data is not counted.
- R9: `err_pulse[3]`: end-of-packet without end-of-burst. The packet still completes and is reported.
- R10: `err_pulse[4]`: start-of-packet without start-of-burst. The start-of-packet strobe is otherwise ignored.
- R11: `err_pulse[5]`: `tx_nvalid` above 8. The count is treated as 8.
- R12: `err_pulse` shows, one clock after the cycle, the conditions seen in that cycle. `err_sticky` accumulates their OR until reset.
- R13: `tx_chan` is sampled only in start-of-burst cycles and has no effect in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sop | input | 1 | Start of packet |
| tx_sob | input | 1 | Start of burst |
| tx_eob | input | 1 | End of burst |
| tx_chan | input | 8 | Channel, valid with start-of-burst |
| tx_nvalid | input | 4 | Valid words this cycle, 0 = idle |
| tx_eop_code | input | 4 | Bit 3 end of packet, bits 2:0 bytes in last word |
| pkt_done | output | 1 | Packet completed (one-cycle pulse) |
| pkt_chan | output | 8 | Channel of the completed packet |
| pkt_bytes | output | 24 | Byte total of the completed packet |
| err_pulse | output | 6 | Violations seen in the previous cycle |
| err_sticky | output | 6 | Accumulated violations since reset |

## Verification
Every result of the monitor sits in one output register, so completion, its channel and byte total, and both error vectors are due exactly one clock after the edge that samples the causing cycle. The bench drives each cycle on a falling edge and updates a behavioural model with the same inputs. It compares every output at the next falling edge, after the one rising edge that captures the result. Reset follows the same one-edge rule.

// File: rtl/ilv_mon_pkg.sv
package ilv_mon_pkg;

  // error vector bit positions
  localparam int ERR_DUP_SOP   = 0;
  localparam int ERR_NO_OPEN   = 1;
  localparam int ERR_OUTSIDE   = 2;
  localparam int ERR_EOP_NOEOB = 3;
  localparam int ERR_SOP_NOSOB = 4;
  localparam int ERR_BAD_COUNT = 5;
  localparam int ERR_W         = 6;

  // bytes contributed by one active cycle
  function automatic int unsigned beat_bytes_f(input int unsigned words,
                                               input bit          is_eop,
                                               input int unsigned last_lo,
                                               input int unsigned word_bytes);
    int unsigned last;
    if (words == 0) return 0;
    if (!is_eop) return words * word_bytes;
    last = (last_lo == 0) ? word_bytes : last_lo;
    return (words - 1) * word_bytes + last;
  endfunction

endpackage

// File: rtl/ilv_beat_decode.sv
module ilv_beat_decode #(
  parameter int WORDS      = 8,
  parameter int WORD_BYTES = 8,
  parameter int NV_W       = 4,
  parameter int EOP_W      = 4,
  parameter int BYTES_W    = 7
) (
  input  logic [NV_W-1:0]    nvalid,
  input  logic [EOP_W-1:0]   eop_code,
  output logic               active,
  output logic               cnt_bad,
  output logic               is_eop,
  output logic [BYTES_W-1:0] beat_bytes
);
  logic [NV_W-1:0]  nv_eff;
  logic [EOP_W-2:0] last_lo;

  always_comb begin
    active  = (nvalid != '0);
    cnt_bad = (nvalid > NV_W'(WORDS));
    nv_eff  = cnt_bad ? NV_W'(WORDS) : nvalid;
    is_eop  = eop_code[EOP_W-1];
    last_lo = eop_code[EOP_W-2:0];
    beat_bytes = BYTES_W'(ilv_mon_pkg::beat_bytes_f(32'(nv_eff), is_eop,
                                                    32'(last_lo), WORD_BYTES));
  end

  always_comb begin
    if (active)
      AST_BEAT_BYTES_RANGE: assert (beat_bytes >= BYTES_W'(1) &&
                                    beat_bytes <= BYTES_W'(WORDS * WORD_BYTES)); // R3
  end
endmodule

// File: rtl/ilv_burst_ctx.sv
module ilv_burst_ctx #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            sob,
  input  logic            eob,
  input  logic [CH_W-1:0] chan,
  output logic            in_burst,
  output logic [CH_W-1:0] cur_chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst <= 1'b0;
      cur_chan <= '0;
    end else if (active) begin
      if (sob) begin
        in_burst <= ~eob;
        cur_chan <= chan;
      end else if (eob) begin
        in_burst <= 1'b0;
      end
    end
  end

  AST_EOB_CLOSES: assert property (@(posedge clk) disable iff (rst)
    active && eob |=> !in_burst); // R5
  AST_SOB_LATCHES: assert property (@(posedge clk) disable iff (rst)
    active && sob && !eob |=> in_burst && cur_chan == $past(chan)); // R13
  AST_IDLE_HOLDS_CTX: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(in_burst) && $stable(cur_chan)); // R2
endmodule

// File: rtl/ilv_chan_table.sv
module ilv_chan_table #(
  parameter int CH_W  = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  rd_idx,
  output logic             rd_open,
  output logic [CNT_W-1:0] rd_acc,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_idx,
  input  logic             wr_open,
  input  logic [CNT_W-1:0] wr_acc
);
  localparam int NUM_CH = 1 << CH_W;

  logic [NUM_CH-1:0] open_vec;
  logic [CNT_W-1:0]  acc_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    logic             o_q;
    logic [CNT_W-1:0] a_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        o_q <= 1'b0;
        a_q <= '0;
      end else if (wr_en && wr_idx == CH_W'(g)) begin
        o_q <= wr_open;
        a_q <= wr_acc;
      end
    end
    assign open_vec[g] = o_q;
    assign acc_arr[g]  = a_q;
  end

  assign rd_open = open_vec[rd_idx];
  assign rd_acc  = acc_arr[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_idx == wr_idx |=> (rd_idx != $past(wr_idx)) || (rd_open == $past(wr_open))); // R5
endmodule

// File: rtl/ilv_burst_monitor.sv
module ilv_burst_monitor #(
  parameter int CH_W       = 8,
  parameter int WORDS      = 8,
  parameter int WORD_BYTES = 8,
  parameter int CNT_W      = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_sop,
  input  logic                        tx_sob,
  input  logic                        tx_eob,
  input  logic [CH_W-1:0]             tx_chan,
  input  logic [$clog2(WORDS+1)-1:0]  tx_nvalid,
  input  logic [$clog2(WORD_BYTES):0] tx_eop_code,
  output logic                        pkt_done,
  output logic [CH_W-1:0]             pkt_chan,
  output logic [CNT_W-1:0]            pkt_bytes,
  output logic [ilv_mon_pkg::ERR_W-1:0] err_pulse,
  output logic [ilv_mon_pkg::ERR_W-1:0] err_sticky
);
  import ilv_mon_pkg::*;

  localparam int NV_W    = $clog2(WORDS + 1);
  localparam int EOP_W   = $clog2(WORD_BYTES) + 1;
  localparam int BYTES_W = $clog2(WORDS * WORD_BYTES + 1);

  // decoded cycle
  logic               beat_active, cnt_bad, is_eop;
  logic [BYTES_W-1:0] beat_bytes;

  ilv_beat_decode #(
    .WORDS(WORDS), .WORD_BYTES(WORD_BYTES), .NV_W(NV_W),
    .EOP_W(EOP_W), .BYTES_W(BYTES_W)
  ) u_dec (
    .nvalid(tx_nvalid), .eop_code(tx_eop_code),
    .active(beat_active), .cnt_bad(cnt_bad),
    .is_eop(is_eop), .beat_bytes(beat_bytes)
  );

  // burst context
  logic            in_burst;
  logic [CH_W-1:0] cur_chan;

  ilv_burst_ctx #(.CH_W(CH_W)) u_ctx (
    .clk(clk), .rst(rst), .active(beat_active),
    .sob(tx_sob), .eob(tx_eob), .chan(tx_chan),
    .in_burst(in_burst), .cur_chan(cur_chan)
  );

  // per-channel table
  logic            eff_chan_sel;
  logic [CH_W-1:0] eff_chan;
  logic            rd_open;
  logic [CNT_W-1:0] rd_acc;
  logic            wr_en, wr_open;
  logic [CNT_W-1:0] wr_acc;

  assign eff_chan_sel = tx_sob;
  assign eff_chan     = eff_chan_sel ? tx_chan : cur_chan;

  ilv_chan_table #(.CH_W(CH_W), .CNT_W(CNT_W)) u_tab (
    .clk(clk), .rst(rst),
    .rd_idx(eff_chan), .rd_open(rd_open), .rd_acc(rd_acc),
    .wr_en(wr_en), .wr_idx(eff_chan), .wr_open(wr_open), .wr_acc(wr_acc)
  );

  // named events
  logic             ev_start, ev_outside, ev_dup, ev_noopen;
  logic             ev_eop_noeob, ev_sop_nosob, ev_badcnt;
  logic             live, ev_close;
  logic [CNT_W-1:0] base_acc, total_acc;
  logic [ERR_W-1:0] ev_vec;

  always_comb begin
    ev_start     = beat_active & tx_sob & tx_sop;
    ev_outside   = beat_active & ~tx_sob & ~in_burst;
    ev_dup       = ev_start & rd_open;
    ev_noopen    = beat_active & tx_sob & ~tx_sop & ~rd_open;
    ev_eop_noeob = beat_active & is_eop & ~tx_eob;
    ev_sop_nosob = beat_active & tx_sop & ~tx_sob;
    ev_badcnt    = beat_active & cnt_bad;
    live         = beat_active & ~ev_outside & (ev_start | rd_open);
    ev_close     = live & is_eop;
    base_acc     = ev_start ? '0 : rd_acc;
    total_acc    = base_acc + CNT_W'(beat_bytes);
    wr_en        = live;
    wr_open      = ~is_eop;
    wr_acc       = is_eop ? '0 : total_acc;
    ev_vec                = '0;
    ev_vec[ERR_DUP_SOP]   = ev_dup;
    ev_vec[ERR_NO_OPEN]   = ev_noopen;
    ev_vec[ERR_OUTSIDE]   = ev_outside;
    ev_vec[ERR_EOP_NOEOB] = ev_eop_noeob;
    ev_vec[ERR_SOP_NOSOB] = ev_sop_nosob;
    ev_vec[ERR_BAD_COUNT] = ev_badcnt;
  end

  // output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_done   <= 1'b0;
      pkt_chan   <= '0;
      pkt_bytes  <= '0;
      err_pulse  <= '0;
      err_sticky <= '0;
    end else begin
      pkt_done   <= ev_close;
      if (ev_close) begin
        pkt_chan  <= eff_chan;
        pkt_bytes <= total_acc;
      end
      err_pulse  <= ev_vec;
      err_sticky <= err_sticky | ev_vec;
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !beat_active |=> !pkt_done && err_pulse == '0); // R2
  AST_CLOSE_REPORTS: assert property (@(posedge clk) disable iff (rst)
    ev_close |=> pkt_done && pkt_chan == $past(eff_chan)); // R4
  AST_OUTSIDE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    ev_outside |=> !pkt_done && err_pulse[ERR_OUTSIDE]); // R8
  AST_NOOPEN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ev_noopen |-> !wr_en); // R7
  AST_STICKY_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_sticky & $past(err_sticky)) == $past(err_sticky)); // R12
  AST_PULSE_IN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_sticky & err_pulse) == err_pulse); // R12
  AST_DONE_HAS_BYTES: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> pkt_bytes != '0); // R3
endmodule

// File: tb/ilv_burst_monitor_bench.sv
module ilv_burst_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 256;

  logic       clk = 1'b0;
  logic       rst;
  logic       tx_sop, tx_sob, tx_eob;
  logic [7:0] tx_chan;
  logic [3:0] tx_nvalid, tx_eop_code;
  logic       pkt_done;
  logic [7:0] pkt_chan;
  logic [23:0] pkt_bytes;
  logic [5:0] err_pulse, err_sticky;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_burst_monitor u_ilv_burst_monitor (
    .clk(clk), .rst(rst), .tx_sop(tx_sop), .tx_sob(tx_sob), .tx_eob(tx_eob),
    .tx_chan(tx_chan), .tx_nvalid(tx_nvalid), .tx_eop_code(tx_eop_code),
    .pkt_done(pkt_done), .pkt_chan(pkt_chan), .pkt_bytes(pkt_bytes),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  bit          m_open [NCH];
  int unsigned m_acc  [NCH];
  bit          m_inb;
  int unsigned m_cur;
  bit          e_done;
  int unsigned e_chan, e_bytes;
  bit [5:0]    e_pulse, e_sticky;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_open[i] = 0; m_acc[i] = 0; end
    m_inb = 0; m_cur = 0;
    e_done = 0; e_chan = 0; e_bytes = 0; e_pulse = 0; e_sticky = 0;
  endtask

  task automatic model_step(input bit sop, sob, eob, input int unsigned ch,
                            input int unsigned nv, input int unsigned eop);
    int unsigned n, c, add, lo;
    bit fin;
    e_done = 0; e_pulse = 0;
    if (nv != 0) begin
      n   = (nv > 8) ? 8 : nv;
      c   = sob ? ch : m_cur;
      fin = (eop >= 8);
      lo  = eop % 8;
      if (nv > 8) e_pulse[5] = 1;
      if (sop && !sob) e_pulse[4] = 1;
      if (fin && !eob) e_pulse[3] = 1;
      if (!sob && !m_inb) e_pulse[2] = 1;
      else begin
        if (sob && sop && m_open[c]) e_pulse[0] = 1;
        if (sob && !sop && !m_open[c]) e_pulse[1] = 1;
        if (sob && sop) begin m_acc[c] = 0; m_open[c] = 1; end
        if (m_open[c]) begin
          add = fin ? (n - 1) * 8 + ((lo == 0) ? 8 : lo) : n * 8;
          m_acc[c] += add;
          if (fin) begin
            e_done = 1; e_chan = c; e_bytes = m_acc[c] % (1 << 24);
            m_open[c] = 0; m_acc[c] = 0;
          end
        end
      end
      if (sob) begin m_inb = !eob; m_cur = ch; end
      else if (eob) m_inb = 0;
    end
    e_sticky |= e_pulse;
  endtask

  task automatic compare(input string tag);
    check(pkt_done == e_done, tag, "pkt_done", pkt_done, e_done);
    if (e_done) begin
      check(pkt_chan == e_chan[7:0], tag, "pkt_chan", pkt_chan, e_chan);
      check(pkt_bytes == e_bytes[23:0], tag, "pkt_bytes", pkt_bytes, e_bytes);
    end
    check(err_pulse == e_pulse, tag, "err_pulse", err_pulse, e_pulse);
    check(err_sticky == e_sticky, tag, "err_sticky", err_sticky, e_sticky);
  endtask

  task automatic beat(input bit sop, sob, eob, input int unsigned ch,
                      input int unsigned nv, input int unsigned eop, input string tag);
    tx_sop = sop; tx_sob = sob; tx_eob = eob; tx_chan = ch[7:0];
    tx_nvalid = nv[3:0]; tx_eop_code = eop[3:0];
    model_step(sop, sob, eob, ch, nv, eop);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1; tx_sop = 0; tx_sob = 0; tx_eob = 0; tx_chan = 0;
    tx_nvalid = 0; tx_eop_code = 0;
    model_reset();
    @(negedge clk);
    compare(tag);
    check(pkt_chan == 0 && pkt_bytes == 0, tag, "reset data", pkt_bytes, 0);
    rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset("R1");
    // interleaved flow: ch2 spans three bursts, ch4 and ch3 in between
    beat(1, 1, 0, 2, 8, 0, "R5");
    beat(0, 0, 1, 99, 8, 0, "R13");        // chan ignored mid burst
    beat(1, 1, 1, 4, 3, 4'hB, "R3");       // ch4 done, 16+3 = 19
    check(e_bytes == 19, "R3", "model ch4", e_bytes, 19);
    beat(1, 1, 1, 7, 0, 4'hB, "R2");       // idle with junk strobes
    beat(0, 1, 1, 2, 8, 0, "R5");
    beat(1, 1, 1, 3, 8, 0, "R5");
    beat(0, 1, 0, 2, 8, 0, "R5");
    beat(0, 0, 1, 55, 2, 4'hB, "R4");      // ch2 done 4*64+11 = 267
    check(e_bytes == 267, "R4", "model ch2", e_bytes, 267);
    beat(0, 1, 1, 3, 1, 4'h8, "R3");       // ch3 done 64+8 = 72
    beat(1, 1, 1, 10, 8, 4'h8, "R3");      // 64
    beat(1, 1, 1, 11, 1, 4'h1, "R3");      // 1
    // errors
    beat(1, 1, 1, 5, 4, 0, "R6");
    beat(1, 1, 1, 5, 2, 0, "R6");          // duplicate start, restart at 16
    beat(0, 1, 1, 5, 1, 4'h8, "R6");       // done 24
    beat(0, 1, 0, 6, 3, 0, "R7");
    beat(0, 0, 1, 6, 2, 4'h8, "R7");       // dropped, no done
    beat(0, 0, 0, 1, 5, 0, "R8");
    beat(0, 0, 1, 1, 2, 4'h8, "R8");
    beat(1, 1, 0, 7, 2, 4'h8, "R9");       // done 16 with error
    beat(0, 0, 1, 7, 1, 0, "R9");
    beat(1, 1, 0, 8, 2, 0, "R10");
    beat(1, 0, 1, 8, 2, 4'h8, "R10");      // done 32
    beat(1, 1, 1, 9, 12, 4'h8, "R11");     // clamp, done 64
    beat(0, 0, 0, 0, 0, 0, "R12");         // pulse clears, sticky holds
    // reset mid packet closes channel
    beat(1, 1, 0, 12, 8, 0, "R1");
    do_reset("R1");
    beat(0, 1, 1, 12, 1, 4'h8, "R1");      // channel closed after reset
    // mixed stimulus over a few channels
    for (int i = 0; i < 4000; i++) begin
      int unsigned nv, eop;
      nv  = ($urandom % 5 == 0) ? 0 : ($urandom % 10);
      eop = ($urandom % 3 == 0) ? (8 + $urandom % 8) : 0;
      beat($urandom % 3 == 0, $urandom % 2 == 0, $urandom % 2 == 0,
           $urandom % 6, nv, eop, "R5");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule